// File: doc/BRIEF.md
# Wide Parallel Magnitude Comparator

This block compares two unsigned words of W bits (64 by default) and reports exactly one of three relations: the words are equal, the first is greater, or the first is smaller. It does not XOR the words and priority-encode the first mismatch. It forms two one-sided difference vectors instead. One marks the bits where A has a one and B a zero, and the other marks the reverse. Each vector becomes a leading-run mask that is 1 at every position strictly above its highest set bit. Each mask bit is a wide NOR of the vector's higher bits, and all of them are evaluated side by side.

The two masks are then cross-combined and OR-reduced. The vector whose highest set bit sits higher yields the shorter run of ones. A non-zero value of "other mask AND NOT own mask" therefore names the larger operand. When the parameter PIPE is 1, a register stage sits between the mask step and the reduction step. The block then returns one result per clock with a latency of one clock, and a valid flag moves along with the data. When PIPE is 0, the path is purely combinational.

Top module: `mag_cmp_wide`

## Requirements
- R1: `a_gt` is 1 exactly when `a` is greater than `b` as an unsigned number, judged on the operands of the sample that produced the result.
- R2: `a_lt` is 1 exactly when `a` is smaller than `b` as an unsigned number.
- R3: `a_eq` is 1 exactly when every bit of `a` matches the same bit of `b`, and for every input pair exactly one of `a_eq`, `a_gt`, `a_lt` is 1.
- R4: Only the most significant bit position where the words differ decides the result. This holds whichever way the lower bits disagree, including words that differ only in bit W-1 or only in bit 0.
- R5: With PIPE=1, operands and `in_valid` sampled at a rising clock edge show up on the outputs after that edge and are held until the next edge. `out_valid` equals the `in_valid` sampled at that edge. With PIPE=0, the outputs follow the inputs in the same cycle.
- R6: While `rst_n` is low, the register stage clears. The outputs then show `out_valid`=0, `a_eq`=1, `a_gt`=0 and `a_lt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `a` and `b` as a sample to compare |
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| out_valid | output | 1 | Marks the result outputs as belonging to a valid sample |
| a_eq | output | 1 | The operands are equal |
| a_gt | output | 1 | The first operand is greater |
| a_lt | output | 1 | The first operand is smaller |

## Verification
Several properties are checked on every clock. Exactly one of the three results is high. The two difference vectors never share a set bit. Each mask is a contiguous run of ones from the top that never covers a set bit of its own vector. Each result matches the relational operators applied to the operands sampled one edge earlier, and `out_valid` trails `in_valid` by one edge. Only the bench's scenarios can show the following: the reset values, that a result holds until the next edge rather than passing through early, and the behaviour at the all-zero, all-ones, MSB-only and LSB-only corner pairs. Those scenarios also show that back-to-back samples with idle gaps between them keep their valid flags aligned.

// File: rtl/magcmp_pkg.sv
`timescale 1ns/1ps
package magcmp_pkg;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmp_res_t;

  // Turn the two reduction flags into the three-way result.
  function automatic cmp_res_t decide(input logic any_gt, input logic any_lt);
    cmp_res_t r;
    r.gt = any_gt & ~any_lt;
    r.lt = any_lt & ~any_gt;
    r.eq = ~any_gt & ~any_lt;
    return r;
  endfunction

endpackage

// File: rtl/mcw_dirvec.sv
`timescale 1ns/1ps
module mcw_dirvec #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_over,
  output logic [W-1:0] b_over
);
  // One-sided difference vectors: where a alone holds a one, where b alone does.
  assign a_over = a & ~b;
  assign b_over = ~a & b;
endmodule

// File: rtl/mcw_leadmask.sv
`timescale 1ns/1ps
module mcw_leadmask #(
  parameter int W = 64
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] mask
);
  // mask[i] is 1 when vec holds no one at i or above, so the ones fill the
  // positions strictly above the highest set bit. Every bit is an independent NOR.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = ~(|vec[W-1:i]);
  end
endmodule

// File: rtl/mcw_crossreduce.sv
`timescale 1ns/1ps
module mcw_crossreduce
  import magcmp_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] mask_g,
  input  logic [W-1:0] mask_l,
  output cmp_res_t     res
);
  logic [W-1:0] g_wins;
  logic [W-1:0] l_wins;
  // The vector with the higher leading one has the shorter run of ones.
  assign g_wins = ~mask_g & mask_l;
  assign l_wins = mask_g & ~mask_l;
  assign res    = decide(|g_wins, |l_wins);
endmodule

// File: rtl/mag_cmp_wide.sv
`timescale 1ns/1ps
module mag_cmp_wide
  import magcmp_pkg::*;
#(
  parameter int W    = 64,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic         a_eq,
  output logic         a_gt,
  output logic         a_lt
);
  logic [W-1:0] g_vec;
  logic [W-1:0] l_vec;
  logic [W-1:0] mask_g_d;
  logic [W-1:0] mask_l_d;
  logic [W-1:0] mask_g_s;
  logic [W-1:0] mask_l_s;
  logic         valid_s;
  cmp_res_t     res;

  mcw_dirvec #(.W(W)) u_dir (
    .a      (a),
    .b      (b),
    .a_over (g_vec),
    .b_over (l_vec)
  );

  mcw_leadmask #(.W(W)) u_mask_g (.vec(g_vec), .mask(mask_g_d));
  mcw_leadmask #(.W(W)) u_mask_l (.vec(l_vec), .mask(mask_l_d));

  if (PIPE) begin : g_stage
    logic [W-1:0] mg_q;
    logic [W-1:0] ml_q;
    logic         v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mg_q <= '0;
        ml_q <= '0;
        v_q  <= 1'b0;
      end else begin
        mg_q <= mask_g_d;
        ml_q <= mask_l_d;
        v_q  <= in_valid;
      end
    end
    assign mask_g_s = mg_q;
    assign mask_l_s = ml_q;
    assign valid_s  = v_q;
  end else begin : g_flow
    assign mask_g_s = mask_g_d;
    assign mask_l_s = mask_l_d;
    assign valid_s  = in_valid;
  end

  mcw_crossreduce #(.W(W)) u_red (
    .mask_g (mask_g_s),
    .mask_l (mask_l_s),
    .res    (res)
  );

  assign out_valid = valid_s;
  assign a_eq      = res.eq;
  assign a_gt      = res.gt;
  assign a_lt      = res.lt;
endmodule

// File: rtl/mag_cmp_wide_chk.sv
`timescale 1ns/1ps
module mag_cmp_wide_chk #(
  parameter int W    = 64,
  parameter bit PIPE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_valid,
  input logic         a_eq,
  input logic         a_gt,
  input logic         a_lt,
  input logic [W-1:0] g_vec,
  input logic [W-1:0] l_vec,
  input logic [W-1:0] mask_g,
  input logic [W-1:0] mask_l
);
  a_r3_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({a_eq, a_gt, a_lt}) == 1);

  a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (g_vec & l_vec) == '0);

  a_r4_run_g: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_g & ~{1'b1, mask_g[W-1:1]}) == '0 && (mask_g & g_vec) == '0);

  a_r4_run_l: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_l & ~{1'b1, mask_l[W-1:1]}) == '0 && (mask_l & l_vec) == '0);

  if (PIPE) begin : g_seq
    a_r5_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r5_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r1_gt: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (a_gt == $past(a > b)));
    a_r2_lt: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (a_lt == $past(a < b)));
    a_r3_eq: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (a_eq == $past(a == b)));
  end else begin : g_comb
    a_r1_gt: assert property (@(posedge clk) disable iff (!rst_n)
      a_gt == (a > b));
    a_r2_lt: assert property (@(posedge clk) disable iff (!rst_n)
      a_lt == (a < b));
    a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end
endmodule

bind mag_cmp_wide mag_cmp_wide_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .a_eq      (a_eq),
  .a_gt      (a_gt),
  .a_lt      (a_lt),
  .g_vec     (g_vec),
  .l_vec     (l_vec),
  .mask_g    (mask_g_d),
  .mask_l    (mask_l_d)
);

// File: tb/tb_mag_cmp_wide.sv
`timescale 1ns/1ps
module tb_mag_cmp_wide;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};
  localparam int NV = 10;

  // Each entry: {a, b}
  localparam logic [2*W-1:0] VEC [NV] = '{
    {64'h0, 64'h0},
    {ONES, ONES},
    {64'h0, ONES},
    {ONES, 64'h0},
    {TOP, 64'h0},
    {ONES, ONES ^ TOP},
    {64'h1, 64'h0},
    {ONES ^ 64'h1, ONES},
    {TOP, ONES ^ TOP},
    {64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEE}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         out_valid, a_eq, a_gt, a_lt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic p_eq = 1'b1, p_gt = 1'b0, p_lt = 1'b0;

  always #10 clk = ~clk;

  mag_cmp_wide #(.W(W), .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .a_eq(a_eq), .a_gt(a_gt), .a_lt(a_lt)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Drive one sample, confirm the old result holds before the edge, then check the new one.
  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
    @(negedge clk);
    a = va; b = vb; in_valid = 1'b1;
    #1;
    chk("R5", "hold-before-edge gt", a_gt, p_gt);
    chk("R5", "hold-before-edge eq", a_eq, p_eq);
    @(negedge clk);
    chk("R5", "out_valid", out_valid, 1'b1);
    chk({"R1 ", tag}, "a_gt", a_gt, va > vb);
    chk({"R2 ", tag}, "a_lt", a_lt, va < vb);
    chk({"R3 ", tag}, "a_eq", a_eq, va == vb);
    p_gt = va > vb; p_lt = va < vb; p_eq = va == vb;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R6", "reset out_valid", out_valid, 1'b0);
    chk("R6", "reset a_eq", a_eq, 1'b1);
    chk("R6", "reset a_gt", a_gt, 1'b0);
    chk("R6", "reset a_lt", a_lt, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VEC[i][2*W-1:W], VEC[i][W-1:0], (i >= 4 && i <= 8) ? "R4" : "table");

    // R4: a single differing bit decides, lower bits disagreeing the other way
    for (int k = 0; k < W; k += 7) begin
      logic [W-1:0] base = {$urandom, $urandom};
      logic [W-1:0] bit_k = {{(W-1){1'b0}}, 1'b1} << k;
      logic [W-1:0] low = bit_k - 1;
      apply((base | bit_k) & ~low, (base & ~bit_k) | low, "R4");
    end

    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] ra = {$urandom, $urandom};
      logic [W-1:0] rb = (n % 3 == 0) ? ra ^ ({$urandom, $urandom} >> (n % W)) : {$urandom, $urandom};
      apply(ra, rb, "random");
    end

    // R5: an idle cycle yields out_valid low after the edge
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5", "idle out_valid", out_valid, 1'b0);

    apply(ONES, 64'h0, "R1");
    // R6: reset in mid-run clears the stage
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6", "mid reset out_valid", out_valid, 1'b0);
    chk("R6", "mid reset a_gt", a_gt, 1'b0);
    chk("R6", "mid reset a_eq", a_eq, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule